// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges three reset sources into one internal core reset: a bidirectional open-drain reset pin, a filtered low-supply flag, and a watchdog underflow pulse. Every source runs through the same sequence. First the block pulls the pin low through its open-drain output for a minimum number of cycles. It then waits until the pin is high again, so an external pulse that outlasts the block's own drive keeps the device in reset. Next comes a fixed delay of CPU cycles, and finally a one-cycle vector-fetch strobe. The core reset output is released through a two-stage synchronizer.

A low on the pin counts as a reset only if it lasts a minimum number of clock cycles. The low-supply flag has to stay in a new state for a filter length before the block acts on it. While the block drives the pin itself, it ignores the pin as an input. A sticky cause register records which source started each sequence. When sources arrive in the same cycle, only the highest-priority one is recorded. Software clears the register with a one-cycle pulse.

Top module: `rst_seq_mgr`

## Requirements
- R1: While `por_n` is low, `pin_drive_low`=1, `core_rst`=1, `vec_fetch`=0 and `reset_cause`=3'b001. After `por_n` rises, one full sequence runs and ends with a vector fetch.
- R2: `pin_in` low for IN_MIN or more consecutive clock cycles starts a sequence. A low of fewer than IN_MIN cycles is ignored: no drive, no fetch, cause unchanged.
- R3: The block's own drive of the pin is never taken as an external reset, so one source event produces exactly one sequence.
- R4: For watchdog or pin sources with the supply flag clear, `pin_drive_low` is high for exactly OUT_MIN cycles. It starts in the cycle after the clock edge that recognizes the source, and `core_rst` is high whenever the pin is driven.
- R5: `lvd_low` held for fewer than LVD_FILT cycles is ignored. Once the filtered flag is set, the pin stays driven low for as long as it remains set.
- R6: If the pin is still held low from outside when the block's drive ends, the block stays in reset with no fetch. The delay starts only after the pin reads high.
- R7: `vec_fetch` is high for one cycle, DELAY_CYC+2 clock edges after the first edge that samples the pin high.
- R8: `core_rst` stays high for the two cycles after the fetch cycle and is low from the third.
- R9: `reset_cause` bits: [2] watchdog, [1] pin, [0] supply/power-on. When sources coincide, only one bit is recorded, with priority watchdog over pin over supply.
- R10: Cause bits accumulate across sequences until a `cause_clr` pulse zeroes them. A source recognized in the same cycle as the clear leaves only its own bit.
- R11: A single-cycle `wdg_uflow` pulse in normal run starts a sequence with OUT_MIN cycles of pin drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, kept running during halt |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pin_in | input | 1 | Level read back from the reset pin |
| lvd_low | input | 1 | Hysteretic supply-below-threshold flag, raw |
| wdg_uflow | input | 1 | Watchdog underflow, one-cycle pulse in clk domain |
| cause_clr | input | 1 | Software pulse that clears the cause register |
| pin_drive_low | output | 1 | Open-drain enable: 1 pulls the reset pin low |
| core_rst | output | 1 | Internal core reset, active high |
| vec_fetch | output | 1 | One-cycle reset-vector fetch request |
| reset_cause | output | 3 | Sticky cause flags {watchdog, pin, supply} |

## Verification
The assertions assume that `wdg_uflow` and `cause_clr` are synchronous to `clk` and last one cycle. They also assume that `por_n` is low at time zero, and that `pin_in` is the wired-AND of the block's drive and any outside pull. The bench keeps within these limits. It changes every input only on the falling clock edge and models the pin as low whenever the block drives it or the bench pulls it. It raises the watchdog pulse only during normal run. Coincidence cases are built by starting the pin low and the supply flag in known cycles, so that their synchronizer and filter delays land on the same recognition edge.

// File: rtl/rsm_pkg.sv
package rsm_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_DRIVE,
    ST_WAIT_HI,
    ST_DELAY,
    ST_FETCH
  } rsm_state_e;

  localparam int CAUSE_W = 3;

  // Priority: watchdog, then pin, then supply. One-hot result.
  function automatic logic [CAUSE_W-1:0] pick_src(input logic wdg, input logic ext,
                                                  input logic lvd);
    if (wdg)      return 3'b100;
    else if (ext) return 3'b010;
    else if (lvd) return 3'b001;
    else          return 3'b000;
  endfunction

  // Bits needed to hold values 0..n.
  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rsm_sync.sv
module rsm_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RST_VAL;
      q  <= RST_VAL;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/rsm_pin_qual.sv
module rsm_pin_qual
  import rsm_pkg::*;
#(
  parameter int IN_MIN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic mask,
  output logic ext_hit
);
  localparam int CW = cnt_bits(IN_MIN);
  localparam logic [CW-1:0] LAST = CW'(IN_MIN - 1);
  localparam logic [CW-1:0] SAT  = CW'(IN_MIN);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               low_cnt <= '0;
    else if (mask || pin_s)   low_cnt <= '0;
    else if (low_cnt != SAT)  low_cnt <= low_cnt + 1'b1;
  end

  // The IN_MIN-th consecutive low sample qualifies the pulse.
  assign ext_hit = !mask && !pin_s && (low_cnt >= LAST);
endmodule

// File: rtl/rsm_glitch_filt.sv
module rsm_glitch_filt
  import rsm_pkg::*;
#(
  parameter int FILT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int CW = cnt_bits(FILT);
  localparam logic [CW-1:0] LAST = CW'(FILT - 1);

  logic [CW-1:0] diff_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q        <= 1'b0;
      diff_cnt <= '0;
    end else if (d == q) begin
      diff_cnt <= '0;
    end else if (diff_cnt == LAST) begin
      q        <= d;
      diff_cnt <= '0;
    end else begin
      diff_cnt <= diff_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rsm_seq_fsm.sv
module rsm_seq_fsm
  import rsm_pkg::*;
#(
  parameter int OUT_MIN   = 32,
  parameter int DELAY_CYC = 4096
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wdg_uflow,
  input  logic               ext_hit,
  input  logic               lvd_f,
  input  logic               pin_s,
  input  logic               cause_clr,
  output logic               pin_drive_low,
  output logic               rst_req,
  output logic               vec_fetch,
  output logic               seq_busy,
  output logic [CAUSE_W-1:0] src_hit,
  output logic [CAUSE_W-1:0] cause
);
  localparam int CW = cnt_bits(max2(OUT_MIN, DELAY_CYC));
  localparam logic [CW-1:0] DRV_LAST = CW'(OUT_MIN - 1);
  localparam logic [CW-1:0] DLY_LAST = CW'(DELAY_CYC - 1);

  rsm_state_e    st;
  logic [CW-1:0] cnt;

  assign src_hit       = (st == ST_RUN) ? pick_src(wdg_uflow, ext_hit, lvd_f) : '0;
  assign pin_drive_low = (st == ST_DRIVE);
  assign vec_fetch     = (st == ST_FETCH);
  assign seq_busy      = (st != ST_RUN);
  assign rst_req       = seq_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_DRIVE;
      cnt <= '0;
    end else begin
      unique case (st)
        ST_RUN: begin
          if (|src_hit) begin
            st  <= ST_DRIVE;
            cnt <= '0;
          end
        end
        ST_DRIVE: begin
          if (cnt == DRV_LAST) begin
            if (!lvd_f) st <= ST_WAIT_HI;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WAIT_HI: begin
          cnt <= '0;
          if (lvd_f)      st <= ST_DRIVE;
          else if (pin_s) st <= ST_DELAY;
        end
        ST_DELAY: begin
          if (lvd_f) begin
            st  <= ST_DRIVE;
            cnt <= '0;
          end else if (cnt == DLY_LAST) begin
            st <= ST_FETCH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_FETCH: begin
          cnt <= '0;
          st  <= lvd_f ? ST_DRIVE : ST_RUN;
        end
        default: begin
          st  <= ST_DRIVE;
          cnt <= '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause <= 3'b001;
    else        cause <= (cause_clr ? '0 : cause) | src_hit;
  end
endmodule

// File: rtl/rst_seq_mgr.sv
module rst_seq_mgr
  import rsm_pkg::*;
#(
  parameter int IN_MIN    = 16,
  parameter int OUT_MIN   = 32,
  parameter int LVD_FILT  = 16,
  parameter int DELAY_CYC = 4096
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               pin_in,
  input  logic               lvd_low,
  input  logic               wdg_uflow,
  input  logic               cause_clr,
  output logic               pin_drive_low,
  output logic               core_rst,
  output logic               vec_fetch,
  output logic [CAUSE_W-1:0] reset_cause
);
  logic               pin_s;
  logic               lvd_s;
  logic               lvd_f;
  logic               ext_hit;
  logic               seq_busy;
  logic               rst_req;
  logic [CAUSE_W-1:0] src_hit;
  logic               rel_n;
  logic [1:0]         rel_sync;

  rsm_sync #(.RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst_n(por_n), .d(pin_in), .q(pin_s)
  );

  rsm_sync #(.RST_VAL(1'b0)) u_lvd_sync (
    .clk(clk), .rst_n(por_n), .d(lvd_low), .q(lvd_s)
  );

  rsm_glitch_filt #(.FILT(LVD_FILT)) u_lvd_filt (
    .clk(clk), .rst_n(por_n), .d(lvd_s), .q(lvd_f)
  );

  rsm_pin_qual #(.IN_MIN(IN_MIN)) u_pin_qual (
    .clk(clk), .rst_n(por_n), .pin_s(pin_s), .mask(seq_busy), .ext_hit(ext_hit)
  );

  rsm_seq_fsm #(.OUT_MIN(OUT_MIN), .DELAY_CYC(DELAY_CYC)) u_fsm (
    .clk(clk), .rst_n(por_n), .wdg_uflow(wdg_uflow), .ext_hit(ext_hit),
    .lvd_f(lvd_f), .pin_s(pin_s), .cause_clr(cause_clr),
    .pin_drive_low(pin_drive_low), .rst_req(rst_req), .vec_fetch(vec_fetch),
    .seq_busy(seq_busy), .src_hit(src_hit), .cause(reset_cause)
  );

  // Core reset: asserted at once, released through two flops.
  assign rel_n = por_n & ~rst_req;

  always_ff @(posedge clk or negedge rel_n) begin
    if (!rel_n) rel_sync <= 2'b00;
    else        rel_sync <= {rel_sync[0], 1'b1};
  end

  assign core_rst = ~rel_sync[1];
endmodule

// File: rtl/rst_seq_mgr_chk.sv
module rst_seq_mgr_chk
  import rsm_pkg::*;
#(
  parameter int OUT_MIN = 32
) (
  input logic               clk,
  input logic               por_n,
  input logic               pin_drive_low,
  input logic               core_rst,
  input logic               vec_fetch,
  input logic               lvd_filt,
  input logic [CAUSE_W-1:0] src_hit
);
  localparam int RW = cnt_bits(OUT_MIN);
  localparam logic [RW-1:0] RSAT = RW'(OUT_MIN);

  logic [RW-1:0] drv_run;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)             drv_run <= '0;
    else if (!pin_drive_low) drv_run <= '0;
    else if (drv_run != RSAT) drv_run <= drv_run + 1'b1;
  end

  p_drive_width_r4: assert property (@(posedge clk) disable iff (!por_n)
    $fell(pin_drive_low) |-> (drv_run == RSAT));

  p_drive_in_reset_r4: assert property (@(posedge clk) disable iff (!por_n)
    pin_drive_low |-> core_rst);

  p_lvd_hold_r5: assert property (@(posedge clk) disable iff (!por_n)
    lvd_filt |=> pin_drive_low);

  p_fetch_single_r7: assert property (@(posedge clk) disable iff (!por_n)
    vec_fetch |=> !vec_fetch);

  p_fetch_in_reset_r7: assert property (@(posedge clk) disable iff (!por_n)
    vec_fetch |-> core_rst);

  p_release_after_fetch_r8: assert property (@(posedge clk) disable iff (!por_n)
    $fell(core_rst) |-> $past(vec_fetch, 3));

  p_one_cause_r9: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0(src_hit));
endmodule

bind rst_seq_mgr rst_seq_mgr_chk #(.OUT_MIN(OUT_MIN)) u_chk (
  .clk(clk), .por_n(por_n), .pin_drive_low(pin_drive_low), .core_rst(core_rst),
  .vec_fetch(vec_fetch), .lvd_filt(lvd_f), .src_hit(src_hit)
);

// File: tb/rst_seq_mgr_tb.sv
module rst_seq_mgr_tb;
  localparam int IN_MIN    = 16;
  localparam int OUT_MIN   = 32;
  localparam int LVD_FILT  = 16;
  localparam int DELAY_CYC = 4096;

  logic clk = 1'b0;
  logic por_n, ext_low, lvd_low, wdg_uflow, cause_clr;
  logic pin_in, pin_drive_low, core_rst, vec_fetch;
  logic [2:0] reset_cause;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  assign pin_in = ~(ext_low | pin_drive_low);

  rst_seq_mgr #(.IN_MIN(IN_MIN), .OUT_MIN(OUT_MIN), .LVD_FILT(LVD_FILT),
                .DELAY_CYC(DELAY_CYC)) u_dut (
    .clk(clk), .por_n(por_n), .pin_in(pin_in), .lvd_low(lvd_low),
    .wdg_uflow(wdg_uflow), .cause_clr(cause_clr), .pin_drive_low(pin_drive_low),
    .core_rst(core_rst), .vec_fetch(vec_fetch), .reset_cause(reset_cause)
  );

  // kind: 0 pin low pulse, 1 supply flag pulse, 2 watchdog pulse
  typedef struct packed {
    logic [1:0] kind;
    logic [7:0] len;
    logic       hit;
    logic [2:0] cause;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{2'd0, 8'(IN_MIN - 1),   1'b0, 3'b000},
    '{2'd0, 8'(IN_MIN),       1'b1, 3'b010},
    '{2'd0, 8'd3,             1'b0, 3'b000},
    '{2'd1, 8'(LVD_FILT - 1), 1'b0, 3'b000},
    '{2'd1, 8'(LVD_FILT + 4), 1'b1, 3'b001},
    '{2'd2, 8'd1,             1'b1, 3'b100}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_cause();
    @(negedge clk); cause_clr = 1'b1;
    @(negedge clk); cause_clr = 1'b0;
  endtask

  task automatic run_to_done();
    int n = 0;
    @(negedge clk);
    while (!vec_fetch && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(vec_fetch, "R7 fetch strobe reached", int'(vec_fetch), 1);
    repeat (3) @(negedge clk);
    chk(!core_rst, "R8 core reset released", int'(core_rst), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 190000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit seen;
    int n;
    int m;
    por_n = 1'b0; ext_low = 1'b0; lvd_low = 1'b0; wdg_uflow = 1'b0; cause_clr = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pin_drive_low, "R1 drive in reset", int'(pin_drive_low), 1);
    chk(core_rst, "R1 core reset in reset", int'(core_rst), 1);
    chk(!vec_fetch, "R1 no fetch in reset", int'(vec_fetch), 0);
    chk(reset_cause == 3'b001, "R1 cause after power-on", int'(reset_cause), 1);
    por_n = 1'b1;
    run_to_done();
    chk(reset_cause == 3'b001, "R1 cause kept after sequence", int'(reset_cause), 1);

    // Table of stimulus vectors (R2, R5, R11)
    for (int i = 0; i < 6; i++) begin
      string tag;
      tag = (VECS[i].kind == 2'd0) ? "R2" : (VECS[i].kind == 2'd1) ? "R5" : "R11";
      clear_cause();
      seen = 1'b0;
      @(negedge clk);
      if (VECS[i].kind == 2'd0) ext_low = 1'b1;
      else if (VECS[i].kind == 2'd1) lvd_low = 1'b1;
      else wdg_uflow = 1'b1;
      for (int k = 0; k < int'(VECS[i].len); k++) begin
        @(negedge clk);
        seen |= pin_drive_low;
      end
      ext_low = 1'b0; lvd_low = 1'b0; wdg_uflow = 1'b0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        seen |= pin_drive_low;
      end
      chk(seen == VECS[i].hit, {tag, " recognition"}, int'(seen), int'(VECS[i].hit));
      if (VECS[i].hit) run_to_done();
      else chk(!vec_fetch && !core_rst, {tag, " ignored pulse"}, int'(core_rst), 0);
      chk(reset_cause == VECS[i].cause, {tag, " cause"}, int'(reset_cause),
          int'(VECS[i].cause));
    end

    // R4 R7 R8 R11 watchdog timing
    clear_cause();
    @(negedge clk); wdg_uflow = 1'b1;
    @(negedge clk);
    chk(pin_drive_low && core_rst, "R11 drive next cycle", int'(pin_drive_low), 1);
    wdg_uflow = 1'b0;
    n = 1;
    do begin
      @(negedge clk);
      if (pin_drive_low) n++;
    end while (pin_drive_low && n < 1000);
    chk(n == OUT_MIN, "R4 drive width", n, OUT_MIN);
    m = 0;
    while (!vec_fetch && m < 10000) begin
      m++;
      @(negedge clk);
    end
    chk(m == DELAY_CYC + 3, "R7 delay after own release", m, DELAY_CYC + 3);
    @(negedge clk);
    chk(!vec_fetch && core_rst, "R7 one-cycle fetch", int'(vec_fetch), 0);
    @(negedge clk);
    chk(core_rst, "R8 reset held second cycle", int'(core_rst), 1);
    @(negedge clk);
    chk(!core_rst, "R8 reset released third cycle", int'(core_rst), 0);
    // R3 no self-triggered sequence afterwards
    seen = 1'b0;
    repeat (200) begin
      @(negedge clk);
      seen |= pin_drive_low | core_rst;
    end
    chk(!seen, "R3 no second sequence", int'(seen), 0);
    chk(reset_cause == 3'b100, "R3 cause only watchdog", int'(reset_cause), 4);

    // R6 long external pulse
    clear_cause();
    @(negedge clk); ext_low = 1'b1;
    n = 0;
    while (!pin_drive_low && n < 100) begin @(negedge clk); n++; end
    while (pin_drive_low && n < 1000) begin @(negedge clk); n++; end
    seen = 1'b0;
    repeat (100) begin
      @(negedge clk);
      seen |= vec_fetch | !core_rst;
    end
    chk(!seen, "R6 held while pin low", int'(seen), 0);
    ext_low = 1'b0;
    m = 0;
    @(negedge clk);
    while (!vec_fetch && m < 10000) begin
      m++;
      @(negedge clk);
    end
    chk(m == DELAY_CYC + 2, "R6 delay after pin release", m, DELAY_CYC + 2);
    repeat (3) @(negedge clk);
    chk(reset_cause == 3'b010, "R6 cause pin", int'(reset_cause), 2);

    // R5 supply flag holds drive
    clear_cause();
    @(negedge clk); lvd_low = 1'b1;
    repeat (200) @(negedge clk);
    chk(pin_drive_low, "R5 drive held by supply flag", int'(pin_drive_low), 1);
    lvd_low = 1'b0;
    run_to_done();
    chk(reset_cause == 3'b001, "R5 cause supply", int'(reset_cause), 1);

    // R9 pin and supply coincide: pin wins
    clear_cause();
    @(negedge clk); lvd_low = 1'b1;
    @(negedge clk); ext_low = 1'b1;
    repeat (50) @(negedge clk);
    ext_low = 1'b0;
    repeat (5) @(negedge clk);
    lvd_low = 1'b0;
    run_to_done();
    chk(reset_cause == 3'b010, "R9 pin over supply", int'(reset_cause), 2);

    // R9 watchdog and pin coincide: watchdog wins
    clear_cause();
    @(negedge clk); ext_low = 1'b1;
    repeat (IN_MIN + 1) @(negedge clk);
    wdg_uflow = 1'b1;
    @(negedge clk); wdg_uflow = 1'b0;
    repeat (5) @(negedge clk);
    ext_low = 1'b0;
    run_to_done();
    chk(reset_cause == 3'b100, "R9 watchdog over pin", int'(reset_cause), 4);

    // R10 accumulation, then clear colliding with a new source
    @(negedge clk); ext_low = 1'b1;
    repeat (IN_MIN + 2) @(negedge clk);
    ext_low = 1'b0;
    run_to_done();
    chk(reset_cause == 3'b110, "R10 bits accumulate", int'(reset_cause), 6);
    @(negedge clk); wdg_uflow = 1'b1; cause_clr = 1'b1;
    @(negedge clk); wdg_uflow = 1'b0; cause_clr = 1'b0;
    chk(reset_cause == 3'b100, "R10 clear with new source", int'(reset_cause), 4);
    run_to_done();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule